// File: doc/BRIEF.md
# Timed Six-Phase Traffic Light Sequencer

This block runs two traffic lights at a street crossing. It steps through six colour patterns in a fixed loop and drives a red, an amber and a green lamp for each light. Each pattern is held for its own dwell time. The dwell time comes from a chain of counters. A prescaler divides the clock. A small timer counts prescaled units and emits a periodic tick. A postscaler counts ticks up to the dwell count of the current phase. With the default parameters and a 2 MHz clock, the tick period is 32 ms, and a dwell count of 1875 ticks holds a phase for 60 s.

There are two push-buttons. The run button starts and stops the sequence each time it is pressed. While the sequence is stopped, every timing stage holds its value, so a restart continues the interrupted dwell. The step button moves the sequence forward by one phase while it is running, which shortens bench tests. Both buttons are synchronised and edge-detected, so each press causes exactly one action, however long the button is held.

Top module: `tl_sequencer`

## Requirements
- R1: After reset, the sequencer is stopped in phase 0 and all timing counters are cleared. Lamp outputs use bit 2 = red, bit 1 = amber and bit 0 = green. In phase 0, light A shows green (3'b001) and light B shows red (3'b100).
- R2: Each rising edge of the synchronised run button toggles the run flag exactly once. A button held high for many cycles still counts as one press. The same one-press-one-action rule applies to the step button.
- R3: While the sequencer is stopped, the phase and all timer stages hold their values, and step presses are ignored.
- R4: The phases produce these lamp patterns, as light A / light B. Phase 0: green/red. Phase 1: amber/red. Phase 2: red/red. Phase 3: red/green. Phase 4: red/amber. Phase 5: red/red. The two lights never show a non-red lamp at the same time.
- R5: The phase counts up by one at a time and wraps from phase 5 back to phase 0.
- R6: While running, each phase p lasts exactly PRESCALE x TIMER_TOP x DWELL_TICKS[p] clock cycles between consecutive lamp changes.
- R7: If the sequencer is stopped during a phase and then restarted, the phase lasts its normal dwell plus the number of cycles it was stopped.
- R8: A step press while running advances exactly one phase. It restarts the whole timing chain, so the new phase lasts its full dwell, measured from the step-driven change.
- R9: Each light shows exactly one lamp in every cycle. The lamp outputs are registered and follow a phase change by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| step_btn_i | input | 1 | Manual step push-button, asynchronous |
| run_btn_i | input | 1 | Start/stop push-button, asynchronous |
| lamp_a_o | output | 3 | Light A lamps {red, amber, green} |
| lamp_b_o | output | 3 | Light B lamps {red, amber, green} |

## Verification
The assertions assume that every DWELL_TICKS entry is at least 1, that PRESCALE and TIMER_TOP are at least 2, and that button inputs are held steady long enough to pass through the two-flop synchroniser. The bench uses a small configuration of 4 x 3 cycles per tick with dwell counts between 1 and 4 ticks. Under that configuration, each button press is driven on the falling clock edge, held for several cycles and then released. Stop and start presses are placed well inside a phase, so that the run flag never flips in the same cycle as a timed advance.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int unsigned NUM_PHASES = 6;
  localparam int unsigned PH_W       = 3;

  localparam logic [2:0] LAMP_RED   = 3'b100;
  localparam logic [2:0] LAMP_AMBER = 3'b010;
  localparam logic [2:0] LAMP_GREEN = 3'b001;

  localparam logic [PH_W-1:0] PH_FIRST = '0;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(NUM_PHASES - 1);

  typedef struct packed {
    logic [2:0] a;
    logic [2:0] b;
  } lamps_t;

  // Colour pattern for each phase of the loop
  function automatic lamps_t phase_lamps(input logic [PH_W-1:0] ph);
    lamps_t l;
    case (ph)
      3'd0:    begin l.a = LAMP_GREEN; l.b = LAMP_RED;   end
      3'd1:    begin l.a = LAMP_AMBER; l.b = LAMP_RED;   end
      3'd3:    begin l.a = LAMP_RED;   l.b = LAMP_GREEN; end
      3'd4:    begin l.a = LAMP_RED;   l.b = LAMP_AMBER; end
      default: begin l.a = LAMP_RED;   l.b = LAMP_RED;   end
    endcase
    return l;
  endfunction
endpackage

// File: rtl/tl_btn_edge.sv
module tl_btn_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], btn_i};
    last_d = sync_q[STAGES-1];
    rise_o = sync_q[STAGES-1] & ~last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/tl_tick_chain.sv
module tl_tick_chain #(
  parameter int unsigned PRESCALE  = 256,
  parameter int unsigned TIMER_TOP = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = $clog2(PRESCALE);
  localparam int unsigned TMR_W = $clog2(TIMER_TOP);
  localparam logic [PRE_W-1:0] PRE_END = PRE_W'(PRESCALE - 1);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(TIMER_TOP - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             pre_stb;

  always_comb begin
    pre_stb = en_i && (pre_q == PRE_END);
    tick_o  = pre_stb && (tmr_q == TMR_END);
    pre_d   = pre_q;
    tmr_d   = tmr_q;
    if (clr_i) begin
      pre_d = '0;
      tmr_d = '0;
    end else if (en_i) begin
      pre_d = pre_stb ? '0 : pre_q + 1'b1;
      if (pre_stb) tmr_d = tick_o ? '0 : tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      pre_q <= pre_d;
      tmr_q <= tmr_d;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_END && tmr_q <= TMR_END); // R6
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(pre_q) && $stable(tmr_q))); // R3
endmodule

// File: rtl/tl_phase_ctrl.sv
module tl_phase_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned POST_W = 16,
  parameter logic [POST_W-1:0] DWELL_TICKS [NUM_PHASES] =
    '{16'd1875, 16'd94, 16'd31, 16'd1875, 16'd94, 16'd31}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            step_i,
  input  logic            toggle_i,
  output logic            run_o,
  output logic            advance_o,
  output logic [PH_W-1:0] phase_o
);
  logic              run_q, run_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [POST_W-1:0] post_q, post_d;
  logic [POST_W-1:0] dwell_cur;
  logic              last_tick;

  always_comb begin
    dwell_cur = DWELL_TICKS[phase_q];
    last_tick = tick_i && (post_q == dwell_cur - 1'b1);
    advance_o = run_q && (step_i || last_tick);
    run_d     = run_q ^ toggle_i;
    phase_d   = phase_q;
    post_d    = post_q;
    if (advance_o) begin
      phase_d = (phase_q == PH_LAST) ? PH_FIRST : phase_q + 1'b1;
      post_d  = '0;
    end else if (run_q && tick_i) begin
      post_d  = post_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= PH_FIRST;
      post_q  <= '0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      post_q  <= post_d;
    end
  end

  assign run_o   = run_q;
  assign phase_o = phase_q;

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PH_LAST); // R5
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |->
      (($past(phase_q) == PH_LAST && phase_q == PH_FIRST) ||
       (phase_q == $past(phase_q) + 1'b1))); // R5
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> ($stable(phase_q) && $stable(post_q))); // R3
  AST_POST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_q < dwell_cur); // R6
endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_pkg::*;
#(
  parameter int unsigned PRESCALE  = 256,
  parameter int unsigned TIMER_TOP = 250,
  parameter int unsigned POST_W    = 16,
  parameter logic [POST_W-1:0] DWELL_TICKS [NUM_PHASES] =
    '{16'd1875, 16'd94, 16'd31, 16'd1875, 16'd94, 16'd31}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_btn_i,
  input  logic       run_btn_i,
  output logic [2:0] lamp_a_o,
  output logic [2:0] lamp_b_o
);
  localparam int unsigned NUM_BTN = 2;
  localparam lamps_t      LAMPS_RST = phase_lamps(PH_FIRST);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [NUM_BTN-1:0] btn_raw, btn_rise;
  assign btn_raw = {run_btn_i, step_btn_i};

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    tl_btn_edge #(.STAGES(2)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .btn_i (btn_raw[i]),
      .rise_o(btn_rise[i])
    );
  end

  logic            run, advance, tick;
  logic [PH_W-1:0] phase;

  tl_tick_chain #(.PRESCALE(PRESCALE), .TIMER_TOP(TIMER_TOP)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .en_i  (run),
    .clr_i (advance),
    .tick_o(tick)
  );

  tl_phase_ctrl #(.POST_W(POST_W), .DWELL_TICKS(DWELL_TICKS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .step_i   (btn_rise[0]),
    .toggle_i (btn_rise[1]),
    .run_o    (run),
    .advance_o(advance),
    .phase_o  (phase)
  );

  lamps_t lamps_q, lamps_d;
  always_comb lamps_d = phase_lamps(phase);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) lamps_q <= LAMPS_RST;
    else        lamps_q <= lamps_d;
  end

  assign lamp_a_o = lamps_q.a;
  assign lamp_b_o = lamps_q.b;

  AST_ONE_LAMP: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones(lamps_q.a) == 1 && $countones(lamps_q.b) == 1); // R9
  AST_NO_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lamps_q.a == LAMP_RED) || (lamps_q.b == LAMP_RED)); // R4
endmodule

// File: tb/tb_tl_sequencer.sv
module tb_tl_sequencer;
  localparam int unsigned PRE = 4;
  localparam int unsigned TMR = 3;
  localparam int unsigned CPT = PRE * TMR;
  localparam logic [15:0] DW [6] = '{16'd2, 16'd1, 16'd3, 16'd2, 16'd1, 16'd4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_btn = 1'b0;
  logic run_btn = 1'b0;
  logic [2:0] lamp_a, lamp_b;

  always #4 clk = ~clk;

  tl_sequencer #(.PRESCALE(PRE), .TIMER_TOP(TMR), .POST_W(16), .DWELL_TICKS(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .step_btn_i(step_btn), .run_btn_i(run_btn),
    .lamp_a_o(lamp_a), .lamp_b_o(lamp_b)
  );

  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  int chg_cnt = 0;
  int chg_cyc = 0;
  bit mon_on = 1'b0;
  logic [5:0] prev_l;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on) begin
      if ({lamp_a, lamp_b} != prev_l) begin
        chg_cyc = cyc;
        chg_cnt = chg_cnt + 1;
      end
      prev_l = {lamp_a, lamp_b};
    end
  end

  function automatic logic [5:0] exp_lamps(input int ph);
    case (ph)
      0: return {3'b001, 3'b100};
      1: return {3'b010, 3'b100};
      3: return {3'b100, 3'b001};
      4: return {3'b100, 3'b010};
      default: return {3'b100, 3'b100};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_lamps(input string req, input int ph);
    check({lamp_a, lamp_b} == exp_lamps(ph), req, int'({lamp_a, lamp_b}), int'(exp_lamps(ph)));
    check($countones(lamp_a) == 1 && $countones(lamp_b) == 1, "R9 one lamp",
          int'({lamp_a, lamp_b}), 1);
  endtask

  task automatic press(ref logic btn, input int hold, output int at);
    at = cyc;
    btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_change();
    int n;
    n = chg_cnt;
    wait (chg_cnt != n);
  endtask

  initial begin
    int ph, t0, k1, k2, n0, dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    prev_l = {lamp_a, lamp_b};
    mon_on = 1'b1;
    check_lamps("R1 reset lamps", 0);

    // stopped after reset: nothing moves
    repeat (100) @(negedge clk);
    check(chg_cnt == 0, "R1 stopped after reset", chg_cnt, 0);

    // step press ignored while stopped
    press(step_btn, 3, dummy);
    repeat (50) @(negedge clk);
    check(chg_cnt == 0, "R3 step ignored when stopped", chg_cnt, 0);

    // long hold on run: one toggle, sequence starts
    press(run_btn, 12, dummy);
    wait_change();
    @(negedge clk);
    ph = 1;
    check_lamps("R2 started after held press", ph);

    // two full loops of timed phases
    for (int k = 0; k < 12; k++) begin
      t0 = chg_cyc;
      wait_change();
      @(negedge clk);
      check(chg_cyc - t0 == int'(CPT * DW[ph]), "R6 dwell length", chg_cyc - t0,
            int'(CPT * DW[ph]));
      ph = (ph == 5) ? 0 : ph + 1;
      check_lamps(ph == 0 ? "R5 wrap lamps" : "R4 phase lamps", ph);
    end

    // pause in the middle of a phase, with an ignored step
    t0 = chg_cyc;
    repeat (3) @(negedge clk);
    press(run_btn, 2, k1);
    n0 = chg_cnt;
    repeat (60) @(negedge clk);
    check(chg_cnt == n0, "R3 frozen while stopped", chg_cnt, n0);
    press(step_btn, 3, dummy);
    repeat (20) @(negedge clk);
    check(chg_cnt == n0, "R3 step ignored in pause", chg_cnt, n0);
    press(run_btn, 2, k2);
    wait_change();
    @(negedge clk);
    check(chg_cyc - t0 == int'(CPT * DW[ph]) + (k2 - k1), "R7 resume held time",
          chg_cyc - t0, int'(CPT * DW[ph]) + (k2 - k1));
    ph = (ph == 5) ? 0 : ph + 1;
    check_lamps("R7 lamps after resume", ph);

    // step while running, held long: single advance, chain restarted
    for (int s = 0; s < 3; s++) begin
      repeat (2) @(negedge clk);
      n0 = chg_cnt;
      press(step_btn, 8, dummy);
      check(chg_cnt == n0 + 1, "R8 single step advance", chg_cnt, n0 + 1);
      ph = (ph == 5) ? 0 : ph + 1;
      check_lamps("R8 lamps after step", ph);
      t0 = chg_cyc;
      wait_change();
      @(negedge clk);
      check(chg_cyc - t0 == int'(CPT * DW[ph]), "R8 full dwell after step",
            chg_cyc - t0, int'(CPT * DW[ph]));
      ph = (ph == 5) ? 0 : ph + 1;
      check_lamps("R4 lamps after timed advance", ph);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule